// File: doc/BRIEF.md
# Data-Ready and Continuous-Read Controller

This block sits between the conversion core of a 24-bit delta-sigma converter and its serial port. It holds the most recent conversion result in an output register and drives an active-low ready flag that tells the host when that register holds a fresh word. Every result-valid strobe from the core first raises the ready flag for one system clock. The word is written in the following cycle, and the flag falls in that same cycle. A host can therefore never read the register while it is changing. A new result that arrives before the previous one was read simply replaces it.

The block also runs the continuous-read mode. In that mode each fresh result is offered to the serial shifter as three bytes, most significant first, and no read command is needed. While the mode is active, incoming serial bytes are watched for the stop code and the reset code. After a calibration the block tags the first result as one to discard. Sleep and wakeup commands gate result handling. The sync command issues a filter reset and then holds the core until the next serial-clock edge.

Top module: `ready_stream_ctrl`

## Requirements
- R1: After reset, `drdyN` is 1, `resOut` is 0, and `discard`, `txValid`, `contMode`, `filtRst` and `coreHold` are all 0.
- R2: A `resValid` strobe sets `drdyN` to 1 at the next clock edge. At the edge after that, `resOut` takes the strobed word and `drdyN` becomes 0. `resOut` never changes at an edge where `drdyN` goes to, or stays at, 0 unless `drdyN` was 1 in the preceding cycle.
- R3: A `readDone` strobe sets `drdyN` to 1 at the next edge and leaves `resOut` unchanged.
- R4: A new result that arrives while `drdyN` is 0 overwrites the unread word. `drdyN` is then 1 for exactly one cycle before it falls again.
- R5: A `calDone` strobe sets `drdyN` to 0 without changing `resOut`. The first result committed after it has `discard` = 1, and the second has `discard` = 0.
- R6: `cmdRdatac` sets `contMode`. In that mode, every commit makes `txValid` 1, with `txByte` carrying bits 23:16 first. Each `txNext` advances to bits 15:8 and then to bits 7:0. The third `txNext` sets `txValid` to 0 and `drdyN` to 1.
- R7: While `contMode` is 1, a received byte equal to 0x0F clears `contMode` at the next edge. Other byte values (for example 0x12) leave the mode unchanged.
- R8: While `contMode` is 1, a received byte 0xFE clears `contMode`, sets `drdyN` to 1, clears `resOut` to 0 and cancels any pending discard tag. When `contMode` is 0, received bytes have no effect.
- R9: `cmdSleep` sets `drdyN` to 1 at the next edge. Until `cmdWakeup`, every `resValid` strobe is ignored and `resOut` keeps its value. After `cmdWakeup`, results are accepted again.
- R10: `cmdSync` produces a one-cycle `filtRst` pulse at the next edge and raises `coreHold` at that same edge. `coreHold` falls at the edge that samples the first `sclkEdge` strobe after that.
- R11: When a new result is committed during a continuous-mode transfer, the byte sequence restarts from bits 23:16 of the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resValid | input | 1 | Conversion core result strobe |
| resWord | input | 24 | Conversion result from the core |
| calDone | input | 1 | Calibration finished strobe |
| readDone | input | 1 | Command-driven read of the output register completed |
| cmdRdatac | input | 1 | Decoded enter-continuous-read command |
| cmdSleep | input | 1 | Decoded sleep command |
| cmdWakeup | input | 1 | Decoded wakeup command |
| cmdSync | input | 1 | Last serial clock of the sync command |
| sclkEdge | input | 1 | Serial clock edge seen, in the system clock domain |
| rxValid | input | 1 | A received serial byte is complete |
| rxByte | input | 8 | Received serial byte |
| txNext | input | 1 | Shifter took the current byte |
| drdyN | output | 1 | Active-low data-ready flag |
| resOut | output | 24 | Latched result register |
| discard | output | 1 | Current result follows a calibration and must be dropped |
| txValid | output | 1 | A continuous-mode byte is offered |
| txByte | output | 8 | Continuous-mode byte, most significant first |
| contMode | output | 1 | Continuous-read mode active |
| filtRst | output | 1 | One-cycle filter reset pulse |
| coreHold | output | 1 | Modulator held in reset |

## Verification
The bench builds the block with its default parameters: a 24-bit word split into three 8-bit bytes, stop code 0x0F and reset code 0xFE. With these values the whole byte sequence of a continuous transfer is visible, including the restart when a transfer is overwritten. Results can arrive back to back, which reaches the overwrite path where the flag is high for only one cycle. Sleep, calibration tagging and both snooped codes are exercised in states where they compete with a pending result.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef struct packed {
    logic capture;  // hold the incoming word
    logic commit;   // move held word to the output register
    logic tag;      // discard tag for the committed word
    logic advance;  // step to the next byte
    logic clear;    // zero the output register
  } ctlStrobes_t;
endpackage

// File: rtl/rsc_control.sv
module rsc_control
  import rsc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] STOP_CODE = 8'h0F,
  parameter logic [BYTE_W-1:0] RESET_CODE = 8'hFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resValid,
  input  logic              calDone,
  input  logic              readDone,
  input  logic              cmdRdatac,
  input  logic              cmdSleep,
  input  logic              cmdWakeup,
  input  logic              cmdSync,
  input  logic              sclkEdge,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txNext,
  input  logic              lastByte,
  output ctlStrobes_t       strb,
  output logic              drdyN,
  output logic              contMode,
  output logic              txValid,
  output logic              filtRst,
  output logic              coreHold
);
  logic sleeping, updPend, calPend, txActive;
  logic snoopStop, snoopRst, accept, lastTaken, sleepNow;

  always_comb begin
    snoopStop = contMode && rxValid && (rxByte == STOP_CODE);
    snoopRst  = contMode && rxValid && (rxByte == RESET_CODE);
    sleepNow  = sleeping || cmdSleep;
    accept    = resValid && !sleepNow;
    lastTaken = txActive && txNext && lastByte;
    strb.capture = accept;
    strb.commit  = updPend && !snoopRst;
    strb.tag     = calPend;
    strb.advance = txActive && txNext && !updPend;
    strb.clear   = snoopRst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleeping <= 1'b0;
      updPend  <= 1'b0;
      calPend  <= 1'b0;
      contMode <= 1'b0;
      drdyN    <= 1'b1;
      txActive <= 1'b0;
      filtRst  <= 1'b0;
      coreHold <= 1'b0;
    end else begin
      if (cmdSleep) sleeping <= 1'b1;
      else if (cmdWakeup) sleeping <= 1'b0;

      updPend <= accept;

      if (snoopStop || snoopRst) contMode <= 1'b0;
      else if (cmdRdatac) contMode <= 1'b1;

      if (snoopRst) calPend <= 1'b0;
      else if (calDone) calPend <= 1'b1;
      else if (strb.commit) calPend <= 1'b0;

      if (snoopRst || sleepNow || accept) drdyN <= 1'b1;
      else if (updPend) drdyN <= 1'b0;
      else if (calDone) drdyN <= 1'b0;
      else if (readDone || lastTaken) drdyN <= 1'b1;

      if (snoopRst || snoopStop || sleepNow || accept) txActive <= 1'b0;
      else if (updPend) txActive <= contMode;
      else if (readDone || lastTaken) txActive <= 1'b0;

      filtRst <= cmdSync;
      if (cmdSync) coreHold <= 1'b1;
      else if (sclkEdge) coreHold <= 1'b0;
    end
  end

  assign txValid = txActive;
endmodule

// File: rtl/rsc_datapath.sv
module rsc_datapath
  import rsc_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [WORD_W-1:0] resWord,
  output logic [WORD_W-1:0] resOut,
  output logic              discard,
  output logic [BYTE_W-1:0] txByte,
  output logic              lastByte
);
  localparam int NBYTES = WORD_W / BYTE_W;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic [WORD_W-1:0] holdReg;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] lanes [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lanes[g] = resOut[WORD_W-1-g*BYTE_W -: BYTE_W];
  end

  assign lastByte = (idx == IDX_W'(NBYTES - 1));
  assign txByte   = lanes[idx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
      resOut  <= '0;
      discard <= 1'b0;
      idx     <= '0;
    end else begin
      if (strb.capture) holdReg <= resWord;
      if (strb.clear) begin
        resOut  <= '0;
        discard <= 1'b0;
        idx     <= '0;
      end else if (strb.commit) begin
        resOut  <= holdReg;
        discard <= strb.tag;
        idx     <= '0;
      end else if (strb.advance && !lastByte) begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ready_stream_ctrl.sv
module ready_stream_ctrl
  import rsc_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] STOP_CODE = 8'h0F,
  parameter logic [BYTE_W-1:0] RESET_CODE = 8'hFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resValid,
  input  logic [WORD_W-1:0] resWord,
  input  logic              calDone,
  input  logic              readDone,
  input  logic              cmdRdatac,
  input  logic              cmdSleep,
  input  logic              cmdWakeup,
  input  logic              cmdSync,
  input  logic              sclkEdge,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txNext,
  output logic              drdyN,
  output logic [WORD_W-1:0] resOut,
  output logic              discard,
  output logic              txValid,
  output logic [BYTE_W-1:0] txByte,
  output logic              contMode,
  output logic              filtRst,
  output logic              coreHold
);
  ctlStrobes_t strb;
  logic lastByte;

  rsc_control #(.BYTE_W(BYTE_W), .STOP_CODE(STOP_CODE), .RESET_CODE(RESET_CODE)) u_ctl (
    .clk(clk), .rstN(rstN), .resValid(resValid), .calDone(calDone),
    .readDone(readDone), .cmdRdatac(cmdRdatac), .cmdSleep(cmdSleep),
    .cmdWakeup(cmdWakeup), .cmdSync(cmdSync), .sclkEdge(sclkEdge),
    .rxValid(rxValid), .rxByte(rxByte), .txNext(txNext), .lastByte(lastByte),
    .strb(strb), .drdyN(drdyN), .contMode(contMode), .txValid(txValid),
    .filtRst(filtRst), .coreHold(coreHold)
  );

  rsc_datapath #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .resWord(resWord),
    .resOut(resOut), .discard(discard), .txByte(txByte), .lastByte(lastByte)
  );
endmodule

// File: rtl/ready_stream_ctrl_chk.sv
module ready_stream_ctrl_chk #(
  parameter int WORD_W = 24,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] STOP_CODE = 8'h0F
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdSleep,
  input logic              cmdSync,
  input logic              rxValid,
  input logic [BYTE_W-1:0] rxByte,
  input logic              drdyN,
  input logic [WORD_W-1:0] resOut,
  input logic              txValid,
  input logic              contMode,
  input logic              filtRst,
  input logic              coreHold
);
  // R2
  update_behind_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(resOut) && !drdyN) |-> $past(drdyN));
  // R9
  sleep_flag_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdSleep |=> drdyN);
  // R7
  stop_code_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (contMode && rxValid && rxByte == STOP_CODE) |=> !contMode);
  // R6
  stream_in_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (contMode && !drdyN));
  // R10
  filter_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    filtRst |-> $past(cmdSync));
  // R10
  hold_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreHold) |-> filtRst);
endmodule

bind ready_stream_ctrl ready_stream_ctrl_chk #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .STOP_CODE(STOP_CODE)) u_chk (
  .clk(clk), .rstN(rstN), .cmdSleep(cmdSleep), .cmdSync(cmdSync),
  .rxValid(rxValid), .rxByte(rxByte), .drdyN(drdyN), .resOut(resOut),
  .txValid(txValid), .contMode(contMode), .filtRst(filtRst), .coreHold(coreHold)
);

// File: tb/sim_ready_stream_ctrl.sv
module sim_ready_stream_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic resValid = 0, calDone = 0, readDone = 0, cmdRdatac = 0, cmdSleep = 0;
  logic cmdWakeup = 0, cmdSync = 0, sclkEdge = 0, rxValid = 0, txNext = 0;
  logic [23:0] resWord = '0;
  logic [7:0]  rxByte = '0;
  logic drdyN, discard, txValid, contMode, filtRst, coreHold;
  logic [23:0] resOut;
  logic [7:0]  txByte;
  int compared = 0, mismatched = 0;

  always #5 clk = ~clk;

  ready_stream_ctrl u0 (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resWord(resWord),
    .calDone(calDone), .readDone(readDone), .cmdRdatac(cmdRdatac),
    .cmdSleep(cmdSleep), .cmdWakeup(cmdWakeup), .cmdSync(cmdSync),
    .sclkEdge(sclkEdge), .rxValid(rxValid), .rxByte(rxByte), .txNext(txNext),
    .drdyN(drdyN), .resOut(resOut), .discard(discard), .txValid(txValid),
    .txByte(txByte), .contMode(contMode), .filtRst(filtRst), .coreHold(coreHold)
  );

  localparam logic [23:0] VEC [6] = '{24'h000001, 24'h800000, 24'hFFFFFF,
                                      24'h5A5A5A, 24'h123456, 24'h0F00FE};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendResult(input logic [23:0] w);
    resValid = 1; resWord = w; tick(1); resValid = 0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    rxValid = 1; rxByte = b; tick(1); rxValid = 0;
  endtask

  task automatic doRead();
    readDone = 1; tick(1); readDone = 0;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    tick(2);
    // R1 reset state
    check("R1", {31'd0, drdyN}, 1);
    check("R1", {8'd0, resOut}, 0);
    check("R1", {26'd0, discard, txValid, contMode, filtRst, coreHold, 1'b0}, 0);
    rstN = 1; tick(1);

    // R2 R3 table walk
    foreach (VEC[i]) begin
      sendResult(VEC[i]);
      check("R2", {31'd0, drdyN}, 1);
      tick(1);
      check("R2", {31'd0, drdyN}, 0);
      check("R2", {8'd0, resOut}, {8'd0, VEC[i]});
      doRead();
      check("R3", {31'd0, drdyN}, 1);
      check("R3", {8'd0, resOut}, {8'd0, VEC[i]});
    end

    // R4 overwrite of an unread word
    sendResult(24'hAAAAAA); tick(1);
    check("R4", {31'd0, drdyN}, 0);
    sendResult(24'hBBBBBB);
    check("R4", {31'd0, drdyN}, 1);
    check("R4", {8'd0, resOut}, 24'hAAAAAA);
    tick(1);
    check("R4", {31'd0, drdyN}, 0);
    check("R4", {8'd0, resOut}, 24'hBBBBBB);
    // R8 bytes ignored outside continuous mode
    sendByte(8'hFE);
    check("R8", {31'd0, drdyN}, 0);
    check("R8", {8'd0, resOut}, 24'hBBBBBB);
    doRead();

    // R5 calibration tagging
    calDone = 1; tick(1); calDone = 0;
    check("R5", {31'd0, drdyN}, 0);
    check("R5", {8'd0, resOut}, 24'hBBBBBB);
    doRead();
    sendResult(24'h111111); tick(1);
    check("R5", {31'd0, discard}, 1);
    doRead();
    sendResult(24'h222222); tick(1);
    check("R5", {31'd0, discard}, 0);
    doRead();

    // R6 continuous stream
    cmdRdatac = 1; tick(1); cmdRdatac = 0;
    check("R6", {31'd0, contMode}, 1);
    sendResult(24'hA1B2C3); tick(1);
    check("R6", {31'd0, txValid}, 1);
    check("R6", {24'd0, txByte}, 8'hA1);
    txNext = 1; tick(1); txNext = 0;
    check("R6", {24'd0, txByte}, 8'hB2);
    // R11 overwrite mid-stream restarts at top byte
    sendResult(24'hD4E5F6); tick(1);
    check("R11", {24'd0, txByte}, 8'hD4);
    txNext = 1; tick(1);
    check("R6", {24'd0, txByte}, 8'hE5);
    tick(1);
    check("R6", {24'd0, txByte}, 8'hF6);
    check("R6", {31'd0, drdyN}, 0);
    tick(1); txNext = 0;
    check("R6", {31'd0, txValid}, 0);
    check("R6", {31'd0, drdyN}, 1);

    // R7 other byte keeps mode, stop code ends it
    sendByte(8'h12);
    check("R7", {31'd0, contMode}, 1);
    sendByte(8'h0F);
    check("R7", {31'd0, contMode}, 0);

    // R8 reset code in continuous mode
    cmdRdatac = 1; tick(1); cmdRdatac = 0;
    sendResult(24'h777777); tick(1);
    calDone = 1; tick(1); calDone = 0;
    sendByte(8'hFE);
    check("R8", {31'd0, contMode}, 0);
    check("R8", {31'd0, drdyN}, 1);
    check("R8", {8'd0, resOut}, 0);
    sendResult(24'h333333); tick(1);
    check("R8", {31'd0, discard}, 0);
    check("R8", {8'd0, resOut}, 24'h333333);

    // R9 sleep gating
    cmdSleep = 1; tick(1); cmdSleep = 0;
    check("R9", {31'd0, drdyN}, 1);
    sendResult(24'h444444); tick(2);
    check("R9", {31'd0, drdyN}, 1);
    check("R9", {8'd0, resOut}, 24'h333333);
    cmdWakeup = 1; tick(1); cmdWakeup = 0;
    sendResult(24'h555555); tick(1);
    check("R9", {31'd0, drdyN}, 0);
    check("R9", {8'd0, resOut}, 24'h555555);
    doRead();

    // R10 sync timing
    cmdSync = 1; tick(1); cmdSync = 0;
    check("R10", {30'd0, filtRst, coreHold}, 2'b11);
    tick(3);
    check("R10", {30'd0, filtRst, coreHold}, 2'b01);
    sclkEdge = 1; tick(1); sclkEdge = 0;
    check("R10", {31'd0, coreHold}, 0);

    report();
    $finish;
  end
endmodule